// File: doc/BRIEF.md
# Sectored Cache Miss and Refill Controller

This block runs the miss path of a level-one data cache whose tags are sectored. One tag covers two adjacent cache lines, and each of those lines keeps its own coherence state. The cache sits in front of an inclusive level-two cache and a burst system bus. The controller accepts one missing line address at a time and reads the sector for that set. It then decides whether the request hits, hits the tag with the wanted line invalid, or misses the tag.

On a tag miss, the controller first writes back every modified line of the old sector. A victim goes to the level-two cache, which is promoted to modified, when that cache holds the line. Otherwise the victim goes out as a burst write on the system bus. Next the controller fetches the requested line. It takes the line from the level-two cache when that cache has it, and otherwise reads it from memory with a burst and installs it in the level-two cache as well. Finally it rewrites the sector and reports completion together with the outcome and the new line state.

The level-two lookup is a combinational probe: the controller drives a line address, and the surrounding logic returns presence and state in the same cycle. Writes into the level-two state array are single-cycle strobes. A bus transfer is a request held until a one-cycle done pulse arrives.

Top module: `sector_fill_ctrl`

## Requirements
- R1: After reset, req_ready is 1, and done, bus_req and l2_wr are 0. Every line state is invalid.
- R2: The request address is {tag, set, line}, with line as the least significant bit. Line states are encoded I=00, S=01, E=10, M=11. A sector tag matches when it equals the request tag and at least one of the sector's two lines is not I. A match with the requested line not I completes with done_kind=0 and that line's state on done_state, and it causes no bus or level-two traffic.
- R3: The fill source depends on the probe. When the level-two probe hits, the line is filled from level two and takes the probed state. When it misses, the controller issues one read burst with bus_write=0 at byte address line_addr*LINE_BYTES, with the offset bits at zero.
- R4: A line read from memory is installed in level two with state E, and it is reported with done_state=E.
- R5: A tag miss completes with done_kind=2. The sector takes the new tag, and the line not requested becomes I.
- R6: A tag match with the requested line I completes with done_kind=1. The other line of the sector keeps its state.
- R7: A modified victim that the level-two probe finds causes one level-two write with state M and no bus cycle. At that moment level two must hold the line as E.
- R8: A modified victim that the probe misses causes one bus write burst at the victim address, and level two is not written for it.
- R9: When both lines of a replaced sector are modified, line 0 is written back before line 1. All writebacks of a miss precede its fill.
- R10: Only one miss is in flight at a time. req_ready drops after acceptance and returns in the cycle where done pulses, and a request accepted in that cycle sees the sector just written.
- R11: A line filled from level two in state M is taken as M. Level two is then written to E, because ownership moves up.
- R12: bus_req, bus_write and bus_addr stay unchanged until bus_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_line_addr | input | TAG_W+SET_W+1 | Missing line address {tag, set, line} |
| done | output | 1 | One-cycle completion pulse |
| done_kind | output | 2 | 0 hit, 1 tag-hit fill, 2 tag-miss fill |
| done_state | output | 2 | Final state of the requested line |
| probe_addr | output | TAG_W+SET_W+1 | Line address looked up in level two |
| probe_hit | input | 1 | Level two holds probe_addr |
| probe_state | input | 2 | Level-two state of probe_addr |
| l2_wr | output | 1 | Level-two state write strobe |
| l2_wr_addr | output | TAG_W+SET_W+1 | Line address written in level two |
| l2_wr_state | output | 2 | State written in level two |
| bus_req | output | 1 | Burst transfer request, held until done |
| bus_write | output | 1 | 1 write burst, 0 read burst |
| bus_addr | output | TAG_W+SET_W+1+log2(LINE_BYTES) | Burst byte address |
| bus_done | input | 1 | Burst finished |

## Verification
Completion of one miss and acceptance of the next fall in the same cycle. The new request reads the sector in the same clock period in which the previous miss's update has just landed. The bench provokes this by issuing every request in the very cycle it sees done, and the stream aims at a handful of sets so that consecutive requests often share a set. The outcome is judged by comparing each classification, final state and traffic count against a bench model of the sector contents and of level two. A stale sector read would show up as a wrong kind or an unexpected writeback.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    MESI_I = 2'b00,
    MESI_S = 2'b01,
    MESI_E = 2'b10,
    MESI_M = 2'b11
  } mesi_e;

  typedef enum logic [1:0] {
    KIND_HIT     = 2'd0,
    KIND_TAGHIT  = 2'd1,
    KIND_TAGMISS = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLASSIFY,
    ST_WB_LINE0,
    ST_WB_LINE1,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_UPDATE
  } fsm_e;
endpackage

// File: rtl/sfc_sector_store.sv
module sfc_sector_store #(
  parameter int TAG_W = 4,
  parameter int SET_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [SET_W-1:0]       rd_set,
  output logic [TAG_W-1:0]       rd_tag,
  output logic [1:0][1:0]        rd_st,
  input  logic                   wr_en,
  input  logic [SET_W-1:0]       wr_set,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic [1:0][1:0]        wr_st
);
  localparam int SETS = 1 << SET_W;

  // tags carry no reset so they map onto a RAM with a registered read
  logic [TAG_W-1:0] tag_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_set] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_set];
  end

  // line states live in flops so reset can clear them all at once
  logic [1:0] st_q [2][SETS];

  for (genvar ln = 0; ln < 2; ln++) begin : g_line
    for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk) begin
        if (rst)
          st_q[ln][s] <= 2'b00;
        else if (wr_en && (wr_set == SET_W'(s)))
          st_q[ln][s] <= wr_st[ln];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)
        rd_st[ln] <= 2'b00;
      else if (rd_en)
        rd_st[ln] <= st_q[ln][rd_set];
    end
  end
endmodule

// File: rtl/sfc_classify.sv
module sfc_classify
  import sfc_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_line,
  input  logic [TAG_W-1:0] sec_tag,
  input  logic [1:0][1:0]  sec_st,
  output logic [1:0]       kind,
  output logic [1:0]       victim_mod,
  output logic [1:0]       req_st,
  output logic [1:0]       sib_st
);
  logic any_valid;
  logic tag_eq;

  always_comb begin
    req_st    = sec_st[req_line];
    sib_st    = sec_st[~req_line];
    any_valid = (sec_st[0] != MESI_I) || (sec_st[1] != MESI_I);
    tag_eq    = any_valid && (sec_tag == req_tag);
    victim_mod = 2'b00;
    if (tag_eq && (req_st != MESI_I)) begin
      kind = KIND_HIT;
    end else if (tag_eq) begin
      kind = KIND_TAGHIT;
    end else begin
      kind = KIND_TAGMISS;
      victim_mod[0] = (sec_st[0] == MESI_M);
      victim_mod[1] = (sec_st[1] == MESI_M);
    end
  end
endmodule

// File: rtl/sector_fill_ctrl.sv
module sector_fill_ctrl
  import sfc_pkg::*;
#(
  parameter int  TAG_W      = 4,
  parameter int  SET_W      = 3,
  parameter int  LINE_BYTES = 32,
  localparam int LA_W       = TAG_W + SET_W + 1,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int BA_W       = LA_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [LA_W-1:0] req_line_addr,
  output logic            done,
  output logic [1:0]      done_kind,
  output logic [1:0]      done_state,
  output logic [LA_W-1:0] probe_addr,
  input  logic            probe_hit,
  input  logic [1:0]      probe_state,
  output logic            l2_wr,
  output logic [LA_W-1:0] l2_wr_addr,
  output logic [1:0]      l2_wr_state,
  output logic            bus_req,
  output logic            bus_write,
  output logic [BA_W-1:0] bus_addr,
  input  logic            bus_done
);
  fsm_e             st;
  fsm_e             wb_next;
  logic [TAG_W-1:0] a_tag, old_tag;
  logic [SET_W-1:0] a_set;
  logic             a_line;
  logic [1:0]       kind_q, vm_q, sib_q, fill_q;
  logic             wait_q;

  logic             rd_en, wr_en;
  logic [TAG_W-1:0] sec_tag;
  logic [1:0][1:0]  sec_st, wr_st;
  logic [1:0]       c_kind, c_vm, c_req_st, c_sib_st;

  assign req_ready = (st == ST_IDLE);
  assign rd_en     = (st == ST_IDLE) && req_valid;
  assign wr_en     = (st == ST_UPDATE);

  sfc_sector_store #(.TAG_W(TAG_W), .SET_W(SET_W)) i_store (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_set (req_line_addr[SET_W:1]),
    .rd_tag (sec_tag),
    .rd_st  (sec_st),
    .wr_en  (wr_en),
    .wr_set (a_set),
    .wr_tag (a_tag),
    .wr_st  (wr_st)
  );

  sfc_classify #(.TAG_W(TAG_W)) i_classify (
    .req_tag    (a_tag),
    .req_line   (a_line),
    .sec_tag    (sec_tag),
    .sec_st     (sec_st),
    .kind       (c_kind),
    .victim_mod (c_vm),
    .req_st     (c_req_st),
    .sib_st     (c_sib_st)
  );

  always_comb begin
    unique case (st)
      ST_WB_LINE0: probe_addr = {old_tag, a_set, 1'b0};
      ST_WB_LINE1: probe_addr = {old_tag, a_set, 1'b1};
      default:     probe_addr = {a_tag, a_set, a_line};
    endcase
  end

  always_comb begin
    wb_next = ((st == ST_WB_LINE0) && vm_q[1]) ? ST_WB_LINE1 : ST_FILL_REQ;
  end

  always_comb begin
    wr_st          = '0;
    wr_st[a_line]  = fill_q;
    wr_st[~a_line] = (kind_q == KIND_TAGMISS) ? MESI_I : sib_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      a_tag       <= '0;
      a_set       <= '0;
      a_line      <= 1'b0;
      old_tag     <= '0;
      kind_q      <= '0;
      vm_q        <= '0;
      sib_q       <= '0;
      fill_q      <= '0;
      wait_q      <= 1'b0;
      done        <= 1'b0;
      done_kind   <= '0;
      done_state  <= '0;
      l2_wr       <= 1'b0;
      l2_wr_addr  <= '0;
      l2_wr_state <= '0;
      bus_req     <= 1'b0;
      bus_write   <= 1'b0;
      bus_addr    <= '0;
    end else begin
      done  <= 1'b0;
      l2_wr <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            a_tag  <= req_line_addr[LA_W-1 -: TAG_W];
            a_set  <= req_line_addr[SET_W:1];
            a_line <= req_line_addr[0];
            st     <= ST_CLASSIFY;
          end
        end
        ST_CLASSIFY: begin
          kind_q  <= c_kind;
          vm_q    <= c_vm;
          sib_q   <= c_sib_st;
          old_tag <= sec_tag;
          if (c_kind == KIND_HIT) begin
            done       <= 1'b1;
            done_kind  <= KIND_HIT;
            done_state <= c_req_st;
            st         <= ST_IDLE;
          end else if (c_vm[0]) begin
            st <= ST_WB_LINE0;
          end else if (c_vm[1]) begin
            st <= ST_WB_LINE1;
          end else begin
            st <= ST_FILL_REQ;
          end
        end
        ST_WB_LINE0, ST_WB_LINE1: begin
          if (!wait_q) begin
            if (probe_hit) begin
              l2_wr       <= 1'b1;
              l2_wr_addr  <= probe_addr;
              l2_wr_state <= MESI_M;
              st          <= wb_next;
            end else begin
              bus_req   <= 1'b1;
              bus_write <= 1'b1;
              bus_addr  <= {probe_addr, {OFF_W{1'b0}}};
              wait_q    <= 1'b1;
            end
          end else if (bus_done) begin
            bus_req <= 1'b0;
            wait_q  <= 1'b0;
            st      <= wb_next;
          end
        end
        ST_FILL_REQ: begin
          if (probe_hit) begin
            fill_q <= probe_state;
            if (probe_state == MESI_M) begin
              l2_wr       <= 1'b1;
              l2_wr_addr  <= probe_addr;
              l2_wr_state <= MESI_E;
            end
            st <= ST_UPDATE;
          end else begin
            bus_req   <= 1'b1;
            bus_write <= 1'b0;
            bus_addr  <= {probe_addr, {OFF_W{1'b0}}};
            st        <= ST_FILL_WAIT;
          end
        end
        ST_FILL_WAIT: begin
          if (bus_done) begin
            bus_req     <= 1'b0;
            l2_wr       <= 1'b1;
            l2_wr_addr  <= {a_tag, a_set, a_line};
            l2_wr_state <= MESI_E;
            fill_q      <= MESI_E;
            st          <= ST_UPDATE;
          end
        end
        ST_UPDATE: begin
          done       <= 1'b1;
          done_kind  <= kind_q;
          done_state <= fill_q;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int LA_W = 8,
  parameter int BA_W = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            done,
  input logic [1:0]      done_kind,
  input logic [1:0]      done_state,
  input logic            probe_hit,
  input logic [1:0]      probe_state,
  input logic            l2_wr,
  input logic [1:0]      l2_wr_state,
  input logic            bus_req,
  input logic            bus_write,
  input logic [BA_W-1:0] bus_addr,
  input logic            bus_done
);
  logic read_seen;

  always_ff @(posedge clk) begin
    if (rst || done)
      read_seen <= 1'b0;
    else if (bus_req && !bus_write)
      read_seen <= 1'b1;
  end

  p_promote_from_excl_r7: assert property (@(posedge clk) disable iff (rst)
    (l2_wr && l2_wr_state == 2'b11) |-> ($past(probe_hit) && $past(probe_state) == 2'b10));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_done_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_bus_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_write)));

  p_bus_wb_before_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_write) |-> !read_seen);

  p_l2_wb_before_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (l2_wr && l2_wr_state == 2'b11) |-> !read_seen);

  p_fill_state_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (done && done_kind != 2'd0) |-> (done_state != 2'b00));
endmodule

bind sector_fill_ctrl sfc_checker #(.LA_W(LA_W), .BA_W(BA_W)) i_sfc_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .done_kind   (done_kind),
  .done_state  (done_state),
  .probe_hit   (probe_hit),
  .probe_state (probe_state),
  .l2_wr       (l2_wr),
  .l2_wr_state (l2_wr_state),
  .bus_req     (bus_req),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_done    (bus_done)
);

// File: tb/test_sector_fill_ctrl.sv
module test_sector_fill_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 4;
  localparam int SET_W = 3;
  localparam int LINE_BYTES = 32;
  localparam int LA_W = TAG_W + SET_W + 1;
  localparam int OFF_W = 5;
  localparam int BA_W = LA_W + OFF_W;
  localparam int NLINES = 1 << LA_W;
  localparam int NSETS = 1 << SET_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LA_W-1:0] req_line_addr = '0;
  logic done;
  logic [1:0] done_kind, done_state;
  logic [LA_W-1:0] probe_addr;
  logic probe_hit;
  logic [1:0] probe_state;
  logic l2_wr;
  logic [LA_W-1:0] l2_wr_addr;
  logic [1:0] l2_wr_state;
  logic bus_req, bus_write;
  logic [BA_W-1:0] bus_addr;
  logic bus_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // level-two state table acting as the surrounding cache
  logic [1:0] l2m [NLINES];
  assign probe_state = l2m[probe_addr];
  assign probe_hit   = (probe_state != 2'b00);

  sector_fill_ctrl #(.TAG_W(TAG_W), .SET_W(SET_W), .LINE_BYTES(LINE_BYTES)) i_sector_fill_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_line_addr(req_line_addr), .done(done), .done_kind(done_kind),
    .done_state(done_state), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .probe_state(probe_state), .l2_wr(l2_wr), .l2_wr_addr(l2_wr_addr),
    .l2_wr_state(l2_wr_state), .bus_req(bus_req), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_done(bus_done)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // L1 model
  logic [TAG_W-1:0] mtag [NSETS];
  logic [1:0] mst [NSETS][2];

  // observed traffic of the current miss
  int obs_l2m, obs_l2e, obs_bw, obs_br;
  int sum_l2m, sum_bw;
  bit obs_wb1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // level-two write monitor
  always @(negedge clk) begin
    if (!rst && l2_wr) begin
      if (l2_wr_state == 2'b11) begin
        obs_l2m++;
        sum_l2m ^= int'(l2_wr_addr);
        if (obs_br > 0) chk(1'b0, "R9 L2 writeback after fill read", obs_br, 0);
        if (l2_wr_addr[0] == 1'b0 && obs_wb1) chk(1'b0, "R9 line0 after line1", 0, 1);
        if (l2_wr_addr[0]) obs_wb1 = 1'b1;
      end else begin
        obs_l2e++;
      end
      l2m[l2_wr_addr] = l2_wr_state;
    end
  end

  // bus responder
  initial begin
    int d;
    logic [BA_W-1:0] ad;
    logic wr;
    forever begin
      @(negedge clk);
      if (!rst && bus_req && !bus_done) begin
        d = $urandom_range(0, 3);
        ad = bus_addr;
        wr = bus_write;
        chk(ad[OFF_W-1:0] == '0, "R3 burst offset", int'(ad[OFF_W-1:0]), 0);
        for (int i = 0; i < d; i++) begin
          @(negedge clk);
          chk(bus_req && bus_addr == ad && bus_write == wr, "R12 bus hold",
              int'(bus_addr), int'(ad));
        end
        if (wr) begin
          obs_bw++;
          sum_bw ^= int'(ad[BA_W-1:OFF_W]);
          if (obs_br > 0) chk(1'b0, "R9 bus writeback after fill read", obs_br, 0);
          if (ad[OFF_W] == 1'b0 && obs_wb1) chk(1'b0, "R9 line0 after line1", 0, 1);
          if (ad[OFF_W]) obs_wb1 = 1'b1;
        end else begin
          obs_br++;
        end
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
      end
    end
  end

  // issue one request at a negedge where req_ready is high; returns at the done negedge
  task automatic do_req(input logic [LA_W-1:0] a);
    logic [TAG_W-1:0] t;
    logic [SET_W-1:0] s;
    logic ln;
    bit anyv, match;
    int ek, es, e_l2m, e_l2e, e_bw, e_br, es_l2m, es_bw;
    logic [LA_W-1:0] va;
    t = a[LA_W-1 -: TAG_W];
    s = a[SET_W:1];
    ln = a[0];
    e_l2m = 0; e_l2e = 0; e_bw = 0; e_br = 0; es_l2m = 0; es_bw = 0;
    anyv = (mst[s][0] != 2'b00) || (mst[s][1] != 2'b00);
    match = anyv && (mtag[s] == t);
    if (match && mst[s][ln] != 2'b00) begin
      ek = 0;
      es = int'(mst[s][ln]);
    end else begin
      ek = match ? 1 : 2;
      if (!match) begin
        for (int k = 0; k < 2; k++) begin
          if (mst[s][k] == 2'b11) begin
            va = {mtag[s], s, k[0]};
            if (l2m[va] != 2'b00) begin e_l2m++; es_l2m ^= int'(va); end
            else begin e_bw++; es_bw ^= int'(va); end
          end
        end
      end
      if (l2m[a] != 2'b00) begin
        es = int'(l2m[a]);
        if (l2m[a] == 2'b11) e_l2e++;
      end else begin
        es = 2;
        e_br++;
        e_l2e++;
      end
      if (!match) mst[s][~ln] = 2'b00;
      mtag[s] = t;
      mst[s][ln] = es[1:0];
    end
    obs_l2m = 0; obs_l2e = 0; obs_bw = 0; obs_br = 0; sum_l2m = 0; sum_bw = 0; obs_wb1 = 1'b0;
    req_valid = 1'b1;
    req_line_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", int'(req_ready), 0);
    while (!done) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready with done", int'(req_ready), 1);
    chk(int'(done_kind) == ek, "R2 R5 R6 kind", int'(done_kind), ek);
    chk(int'(done_state) == es, "R3 R4 R11 state", int'(done_state), es);
    chk(obs_l2m == e_l2m && sum_l2m == es_l2m, "R7 L2 writebacks", obs_l2m, e_l2m);
    chk(obs_bw == e_bw && sum_bw == es_bw, "R8 bus writebacks", obs_bw, e_bw);
    chk(obs_br == e_br, "R3 memory reads", obs_br, e_br);
    chk(obs_l2e == e_l2e, "R4 R11 L2 installs", obs_l2e, e_l2e);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NLINES; i++) l2m[i] = 2'($urandom_range(0, 3));
    for (int i = 0; i < NSETS; i++) begin
      mtag[i] = '0;
      mst[i][0] = 2'b00;
      mst[i][1] = 2'b00;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(bus_req == 1'b0, "R1 bus_req", int'(bus_req), 0);
    chk(l2_wr == 1'b0, "R1 l2_wr", int'(l2_wr), 0);

    // directed: set 5, tag 1 both lines modified, then replaced by tag 2
    l2m[8'h1A] = 2'b11;
    l2m[8'h1B] = 2'b11;
    l2m[8'h2A] = 2'b00;
    l2m[8'h2B] = 2'b01;
    do_req(8'h1A);          // R5 empty sector, R11 M from L2
    do_req(8'h1B);          // R6 tag-hit fill, sibling kept
    do_req(8'h1A);          // R2 hit, sibling state M survived
    l2m[8'h1B] = 2'b00;     // level two dropped line 1
    do_req(8'h2A);          // R7 line0 to L2, R8 line1 to bus, R9 order, R4 memory fill
    do_req(8'h2B);          // R5 sibling was invalidated: tag-hit fill

    // random stream aimed at a few sets, issued back to back
    for (int n = 0; n < 400; n++) begin
      logic [LA_W-1:0] a;
      a = {4'($urandom_range(0, 3)), 3'($urandom_range(0, 3)), 1'($urandom_range(0, 1))};
      do_req(a);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule